// File: doc/BRIEF.md
# Trap Dispatcher

This block sits at the front of a processor's trap path. Each cycle it looks at one of two kinds of request. The first is a synchronous exception, given as an index. The second is the highest pending interrupt level, together with the interrupt set and enable masks and a per-level mask table. The block decides whether anything is taken. When something is taken, it computes the handler address, the new status word and the values to save, and then raises a taken strobe.

Levels above 1 save the interrupted PC and status into a register pair for that level. They then enter the handler with the status level field raised to that level. A level-1 interrupt does not get a vector of its own. It becomes a kernel, user or double exception, chosen by the exception-mode and user-mode bits. It records its cause code and may save its PC into a separate double-exception register. Every handler address can be moved relative to a run-time vector base.

Top module: `trap_dispatch`

## Requirements
- R1: An interrupt is accepted only when pend_level is greater than ps_in[3:0], is at most NLEVEL, and the AND of that level's mask (level L at level_masks[(L-1)*NINT +: NINT]), int_set and int_en is nonzero. Otherwise taken_o stays low and no output register changes.
- R2: The status word layout is level in bits [3:0], EXCM in bit 4 and UM in bit 5. For an accepted level L above 1, epc_o slot L (bits [(L-1)*AW +: AW]) receives pc_in and eps_o slot L (bits [(L-2)*8 +: 8]) receives ps_in. ps_o becomes ps_in with bits [3:0] set to L and EXCM set. pc_o becomes the level vector DEF_VBASE + 0x400 + 64*L.
- R3: An accepted level-1 interrupt writes cause code 4 into cause_o and sets EXCM in ps_o. All other bits of ps_o are kept.
- R4: A level-1 interrupt with EXCM already set goes to the double-exception vector (index 8). Its PC goes to depc_o when HAS_DEPC is 1, and to epc_o slot 1 otherwise.
- R5: A level-1 interrupt with EXCM clear saves pc_in into epc_o slot 1. It goes to the user vector (index 7) when UM is 1, and to the kernel vector (index 6) when UM is 0.
- R6: With RELOC_EN set, every handler address equals the configured vector minus DEF_VBASE plus vbase_in. With RELOC_EN clear, the configured vector is used unchanged.
- R7: exc_idx values 0 to 9 are ovf4, unf4, ovf8, unf8, ovf12, unf12, kernel, user, double and debug. An index whose EXC_PRESENT bit is set loads pc_o with DEF_VBASE + 64*idx (relocated as in R6) and loads ps_o with ps_in. The saved registers and cause_o are left unchanged.
- R8: An exception index with no configured vector (an EXC_PRESENT bit of 0, or an index of 10 or more) leaves pc_o and ps_o unchanged and keeps taken_o low.
- R9: When exc_valid is high, any interrupt in the same cycle is ignored. The saved registers and cause_o are not written.
- R10: All outputs are registered. taken_o is high in exactly the cycle after an accepted request, and low after any cycle without one.
- R11: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | A synchronous exception is requested this cycle |
| exc_idx | input | 4 | Synchronous exception index |
| pend_level | input | 4 | Highest pending interrupt level, 0 for none |
| int_set | input | NINT | Raised interrupt lines |
| int_en | input | NINT | Interrupt enable mask |
| level_masks | input | NLEVEL*NINT | Per-level interrupt membership masks |
| ps_in | input | 8 | Current status word |
| pc_in | input | AW | Current program counter |
| vbase_in | input | AW | Run-time vector base |
| pc_o | output | AW | Handler address |
| ps_o | output | 8 | Status word after the last taken event |
| taken_o | output | 1 | One-cycle strobe for a taken event |
| cause_o | output | 6 | Exception cause register |
| epc_o | output | NLEVEL*AW | Saved PC per level |
| eps_o | output | (NLEVEL-1)*8 | Saved status for levels 2 and up |
| depc_o | output | AW | Double-exception saved PC |

## Verification
A synchronous exception and a qualified interrupt can arrive in the same cycle. The bench creates this overlap by raising exc_valid for every index from 0 to 15 while a level-1 or level-2 interrupt is pending and fully enabled. It then checks the result against a model written from the requirements. In that model the exception alone decides pc_o and ps_o, while the saved PCs, saved status words and cause_o keep their earlier values. Indices that have no vector must leave everything unchanged, including the interrupt's side effects.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int PSW        = 8;
  localparam int PS_LVL_W   = 4;
  localparam int PS_EXCM    = 4;
  localparam int PS_UM      = 5;
  localparam int CAUSE_W    = 6;
  localparam int EXC_IDX_W  = 4;
  localparam int NUM_EXC    = 10;
  localparam logic [CAUSE_W-1:0] CAUSE_L1_IRQ = 6'd4;

  typedef enum logic [EXC_IDX_W-1:0] {
    EXC_WOF4   = 4'd0,
    EXC_WUF4   = 4'd1,
    EXC_WOF8   = 4'd2,
    EXC_WUF8   = 4'd3,
    EXC_WOF12  = 4'd4,
    EXC_WUF12  = 4'd5,
    EXC_KERNEL = 4'd6,
    EXC_USER   = 4'd7,
    EXC_DOUBLE = 4'd8,
    EXC_DEBUG  = 4'd9
  } exc_id_e;
endpackage

// File: rtl/trap_irq_qual.sv
module trap_irq_qual #(
  parameter int NLEVEL = 4,
  parameter int NINT   = 8,
  parameter int LVLW   = 4
) (
  input  logic [LVLW-1:0]        pend_level,
  input  logic [LVLW-1:0]        cur_level,
  input  logic [NINT-1:0]        int_set,
  input  logic [NINT-1:0]        int_en,
  input  logic [NLEVEL*NINT-1:0] level_masks,
  output logic                   accept,
  output logic                   is_level1
);
  logic [NLEVEL-1:0] lvl_hit;

  // one reduction per configured level
  for (genvar g = 0; g < NLEVEL; g++) begin : g_hit
    assign lvl_hit[g] = |(level_masks[g*NINT +: NINT] & int_set & int_en);
  end

  always_comb begin
    accept = 1'b0;
    for (int l = 1; l <= NLEVEL; l++) begin
      if (pend_level == LVLW'(l) && pend_level > cur_level) begin
        accept = lvl_hit[l-1];
      end
    end
  end

  assign is_level1 = (pend_level == LVLW'(1));
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_pkg::*;
#(
  parameter int                  AW          = 32,
  parameter logic [AW-1:0]       DEF_VBASE   = AW'(32'h4000_0000),
  parameter bit                  RELOC_EN    = 1'b1,
  parameter logic [NUM_EXC-1:0]  EXC_PRESENT = 10'h1FF,
  parameter int                  VEC_STRIDE  = 64,
  parameter int                  IRQ_VEC_OFF = 'h400
) (
  input  logic                 use_level,
  input  logic [PS_LVL_W-1:0]  level,
  input  logic [EXC_IDX_W-1:0] exc_idx,
  input  logic [AW-1:0]        vbase,
  output logic [AW-1:0]        target,
  output logic                 present
);
  logic [AW-1:0] raw_vec;

  always_comb begin
    if (use_level) begin
      raw_vec = DEF_VBASE + AW'(IRQ_VEC_OFF) + AW'(level) * AW'(VEC_STRIDE);
    end else begin
      raw_vec = DEF_VBASE + AW'(exc_idx) * AW'(VEC_STRIDE);
    end
  end

  always_comb begin
    present = use_level;
    for (int i = 0; i < NUM_EXC; i++) begin
      if (!use_level && exc_idx == EXC_IDX_W'(i)) present = EXC_PRESENT[i];
    end
  end

  if (RELOC_EN) begin : g_reloc
    assign target = raw_vec - DEF_VBASE + vbase;
  end else begin : g_fixed
    assign target = raw_vec;
  end
endmodule

// File: rtl/trap_ctx_regs.sv
module trap_ctx_regs
  import trap_pkg::*;
#(
  parameter int AW       = 32,
  parameter int NLEVEL   = 4,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLEVEL-1:0]       epc_we,
  input  logic [NLEVEL-2:0]       eps_we,
  input  logic                    depc_we,
  input  logic                    cause_we,
  input  logic [AW-1:0]           save_pc,
  input  logic [PSW-1:0]          save_ps,
  input  logic [CAUSE_W-1:0]      cause_val,
  output logic [NLEVEL*AW-1:0]    epc_o,
  output logic [(NLEVEL-1)*PSW-1:0] eps_o,
  output logic [AW-1:0]           depc_o,
  output logic [CAUSE_W-1:0]      cause_o
);
  for (genvar l = 0; l < NLEVEL; l++) begin : g_epc
    logic [AW-1:0] epc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         epc_q <= '0;
      else if (epc_we[l]) epc_q <= save_pc;
    end
    assign epc_o[l*AW +: AW] = epc_q;
  end

  for (genvar l = 0; l < NLEVEL-1; l++) begin : g_eps
    logic [PSW-1:0] eps_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         eps_q <= '0;
      else if (eps_we[l]) eps_q <= save_ps;
    end
    assign eps_o[l*PSW +: PSW] = eps_q;
  end

  if (HAS_DEPC) begin : g_depc
    logic [AW-1:0] depc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       depc_q <= '0;
      else if (depc_we) depc_q <= save_pc;
    end
    assign depc_o = depc_q;
  end else begin : g_no_depc
    assign depc_o = '0;
  end

  logic [CAUSE_W-1:0] cause_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_we) cause_q <= cause_val;
  end
  assign cause_o = cause_q;
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_pkg::*;
#(
  parameter int                 AW          = 32,
  parameter int                 NLEVEL      = 4,
  parameter int                 NINT        = 8,
  parameter bit                 HAS_DEPC    = 1'b1,
  parameter bit                 RELOC_EN    = 1'b1,
  parameter logic [AW-1:0]      DEF_VBASE   = AW'(32'h4000_0000),
  parameter logic [NUM_EXC-1:0] EXC_PRESENT = 10'h1FF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      exc_valid,
  input  logic [EXC_IDX_W-1:0]      exc_idx,
  input  logic [PS_LVL_W-1:0]       pend_level,
  input  logic [NINT-1:0]           int_set,
  input  logic [NINT-1:0]           int_en,
  input  logic [NLEVEL*NINT-1:0]    level_masks,
  input  logic [PSW-1:0]            ps_in,
  input  logic [AW-1:0]             pc_in,
  input  logic [AW-1:0]             vbase_in,
  output logic [AW-1:0]             pc_o,
  output logic [PSW-1:0]            ps_o,
  output logic                      taken_o,
  output logic [CAUSE_W-1:0]        cause_o,
  output logic [NLEVEL*AW-1:0]      epc_o,
  output logic [(NLEVEL-1)*PSW-1:0] eps_o,
  output logic [AW-1:0]             depc_o
);
  logic                  irq_acc, irq_l1;
  logic                  use_level;
  logic [EXC_IDX_W-1:0]  vidx;
  logic [AW-1:0]         vec_target;
  logic                  vec_present;
  logic [NLEVEL-1:0]     epc_we;
  logic [NLEVEL-2:0]     eps_we;
  logic                  depc_we, cause_we;
  logic                  taken_d, redirect;
  logic [PSW-1:0]        ps_d;
  logic [AW-1:0]         pc_q;
  logic [PSW-1:0]        ps_q;
  logic                  taken_q;

  trap_irq_qual #(.NLEVEL(NLEVEL), .NINT(NINT), .LVLW(PS_LVL_W)) u_qual (
    .pend_level (pend_level),
    .cur_level  (ps_in[PS_LVL_W-1:0]),
    .int_set    (int_set),
    .int_en     (int_en),
    .level_masks(level_masks),
    .accept     (irq_acc),
    .is_level1  (irq_l1)
  );

  trap_vec_gen #(.AW(AW), .DEF_VBASE(DEF_VBASE), .RELOC_EN(RELOC_EN),
                 .EXC_PRESENT(EXC_PRESENT)) u_vec (
    .use_level(use_level),
    .level    (pend_level),
    .exc_idx  (vidx),
    .vbase    (vbase_in),
    .target   (vec_target),
    .present  (vec_present)
  );

  // next-state decision: exception first, then interrupt
  always_comb begin
    use_level = 1'b0;
    vidx      = exc_idx;
    epc_we    = '0;
    eps_we    = '0;
    depc_we   = 1'b0;
    cause_we  = 1'b0;
    taken_d   = 1'b0;
    redirect  = 1'b0;
    ps_d      = ps_in;
    if (exc_valid) begin
      redirect = vec_present;
      taken_d  = vec_present;
    end else if (irq_acc) begin
      taken_d = 1'b1;
      if (!irq_l1) begin
        use_level = 1'b1;
        for (int l = 2; l <= NLEVEL; l++) begin
          if (pend_level == PS_LVL_W'(l)) begin
            epc_we[l-1] = 1'b1;
            eps_we[l-2] = 1'b1;
          end
        end
        ps_d     = {ps_in[PSW-1:PS_UM], 1'b1, pend_level};
        redirect = 1'b1;
      end else begin
        cause_we = 1'b1;
        if (ps_in[PS_EXCM]) begin
          vidx = EXC_DOUBLE;
          if (HAS_DEPC) depc_we   = 1'b1;
          else          epc_we[0] = 1'b1;
        end else begin
          vidx      = ps_in[PS_UM] ? EXC_USER : EXC_KERNEL;
          epc_we[0] = 1'b1;
        end
        ps_d              = ps_in;
        ps_d[PS_EXCM]     = 1'b1;
        redirect          = vec_present;
      end
    end
  end

  trap_ctx_regs #(.AW(AW), .NLEVEL(NLEVEL), .HAS_DEPC(HAS_DEPC)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .epc_we   (epc_we),
    .eps_we   (eps_we),
    .depc_we  (depc_we),
    .cause_we (cause_we),
    .save_pc  (pc_in),
    .save_ps  (ps_in),
    .cause_val(CAUSE_L1_IRQ),
    .epc_o    (epc_o),
    .eps_o    (eps_o),
    .depc_o   (depc_o),
    .cause_o  (cause_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (redirect) pc_q <= vec_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_q <= '0;
    else if (taken_d) ps_q <= ps_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken_q <= 1'b0;
    else        taken_q <= taken_d;
  end

  assign pc_o    = pc_q;
  assign ps_o    = ps_q;
  assign taken_o = taken_q;

  // R1: a level not above the current one never produces a take
  a_r1_no_low_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && pend_level <= ps_in[PS_LVL_W-1:0]) |=> !taken_o);

  // R2: high level entry raises the level field and EXCM
  a_r2_level_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && irq_acc && pend_level > PS_LVL_W'(1)) |=>
      (ps_o[PS_LVL_W-1:0] == $past(pend_level) && ps_o[PS_EXCM] && taken_o));

  // R3: level-1 entry records its cause and sets EXCM
  a_r3_l1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && irq_acc && pend_level == PS_LVL_W'(1)) |=>
      (cause_o == CAUSE_L1_IRQ && ps_o[PS_EXCM]));

  // R8: an exception without a vector leaves the PC alone
  a_r8_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !vec_present) |=> (!taken_o && $stable(pc_o) && $stable(ps_o)));

  // R9: a same-cycle interrupt is dropped under an exception
  a_r9_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> ($stable(cause_o) && $stable(epc_o) && $stable(eps_o)
                   && $stable(depc_o)));

  // R10: the strobe only follows an accepted request
  a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !irq_acc) |=> !taken_o);
endmodule

// File: tb/sim_trap_dispatch.sv
`timescale 1ns/1ps
module sim_trap_dispatch;
  localparam int AW = 32;
  localparam int NL = 4;
  localparam int NI = 8;
  localparam logic [31:0] DEFB = 32'h4000_0000;

  logic        clk;
  logic        rst_n;
  logic        exc_valid;
  logic [3:0]  exc_idx;
  logic [3:0]  pend_level;
  logic [7:0]  int_set, int_en;
  logic [31:0] level_masks;
  logic [7:0]  ps_in;
  logic [31:0] pc_in, vbase_in;

  logic [31:0]  pc_w   [2];
  logic [7:0]   ps_w   [2];
  logic         tk_w   [2];
  logic [5:0]   cause_w[2];
  logic [127:0] epc_w  [2];
  logic [23:0]  eps_w  [2];
  logic [31:0]  depc_w [2];

  int n_chk;
  int n_fail;

  // model state per configuration (0: DEPC + relocation, 1: neither)
  logic [31:0] m_pc   [2];
  logic [7:0]  m_ps   [2];
  logic        m_tk   [2];
  logic [5:0]  m_cause[2];
  logic [31:0] m_epc  [2][4];
  logic [7:0]  m_eps  [2][3];
  logic [31:0] m_depc [2];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  trap_dispatch #(.HAS_DEPC(1'b1), .RELOC_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_idx(exc_idx),
    .pend_level(pend_level), .int_set(int_set), .int_en(int_en),
    .level_masks(level_masks), .ps_in(ps_in), .pc_in(pc_in), .vbase_in(vbase_in),
    .pc_o(pc_w[0]), .ps_o(ps_w[0]), .taken_o(tk_w[0]), .cause_o(cause_w[0]),
    .epc_o(epc_w[0]), .eps_o(eps_w[0]), .depc_o(depc_w[0]));

  trap_dispatch #(.HAS_DEPC(1'b0), .RELOC_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_idx(exc_idx),
    .pend_level(pend_level), .int_set(int_set), .int_en(int_en),
    .level_masks(level_masks), .ps_in(ps_in), .pc_in(pc_in), .vbase_in(vbase_in),
    .pc_o(pc_w[1]), .ps_o(ps_w[1]), .taken_o(tk_w[1]), .cause_o(cause_w[1]),
    .epc_o(epc_w[1]), .eps_o(eps_w[1]), .depc_o(depc_w[1]));

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] lmask(input int l);
    return 8'h3 << (2 * (l - 1));
  endfunction

  function automatic logic [31:0] vtarget(input int c, input logic [31:0] off);
    // R6: relocated = configured - default base + run-time base
    if (c == 0) return (DEFB + off) - DEFB + vbase_in;
    return DEFB + off;
  endfunction

  string scen;

  task automatic model_step(input int c);
    int lvl;
    int idx;
    bit hit;
    lvl = int'(pend_level);
    m_tk[c] = 1'b0;
    if (exc_valid) begin
      if (exc_idx <= 4'd8) begin
        m_pc[c] = vtarget(c, 32'(exc_idx) * 64);
        m_ps[c] = ps_in;
        m_tk[c] = 1'b1;
      end
    end else begin
      hit = (lvl >= 1) && (lvl <= NL) && (lvl > int'(ps_in[3:0])) &&
            ((lmask(lvl) & int_set & int_en) != 8'h0);
      if (hit) begin
        m_tk[c] = 1'b1;
        if (lvl > 1) begin
          m_epc[c][lvl-1] = pc_in;
          m_eps[c][lvl-2] = ps_in;
          m_ps[c] = (ps_in & 8'hF0) | 8'h10 | 8'(lvl);
          m_pc[c] = vtarget(c, 32'h400 + 32'(lvl) * 64);
        end else begin
          m_cause[c] = 6'd4;
          if (ps_in[4]) begin
            idx = 8;
            if (c == 0) m_depc[c] = pc_in;
            else        m_epc[c][0] = pc_in;
          end else begin
            idx = ps_in[5] ? 7 : 6;
            m_epc[c][0] = pc_in;
          end
          m_ps[c] = ps_in | 8'h10;
          m_pc[c] = vtarget(c, 32'(idx) * 64);
        end
      end
    end
  endtask

  function automatic string scenario();
    int lvl;
    bit hit;
    lvl = int'(pend_level);
    if (exc_valid) begin
      if (exc_idx > 4'd8) return "R8";
      if (pend_level != 4'd0) return "R9";
      return "R7";
    end
    hit = (lvl >= 1) && (lvl <= NL) && (lvl > int'(ps_in[3:0])) &&
          ((lmask(lvl) & int_set & int_en) != 8'h0);
    if (!hit) return "R1";
    if (lvl > 1) return "R2";
    if (ps_in[4]) return "R4";
    return "R5";
  endfunction

  task automatic compare_all();
    for (int c = 0; c < 2; c++) begin
      chk("R10", "taken", 128'(tk_w[c]), 128'(m_tk[c]));
      chk(scen, "pc", 128'(pc_w[c]), 128'(m_pc[c]));
      if (c == 0 && m_tk[c]) chk("R6", "relocated pc", 128'(pc_w[c]), 128'(m_pc[c]));
      chk(scen, "ps", 128'(ps_w[c]), 128'(m_ps[c]));
      chk("R3", "cause", 128'(cause_w[c]), 128'(m_cause[c]));
      chk(scen, "epc", epc_w[c],
          {m_epc[c][3], m_epc[c][2], m_epc[c][1], m_epc[c][0]});
      chk(scen, "eps", 128'(eps_w[c]), 128'({m_eps[c][2], m_eps[c][1], m_eps[c][0]}));
      chk(scen, "depc", 128'(depc_w[c]), 128'(m_depc[c]));
    end
  endtask

  // inputs already set after a falling edge; model, wait one edge, check
  task automatic do_step();
    scen = scenario();
    model_step(0);
    model_step(1);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [7:0] set_pat(input int p, input int lvl);
    case (p)
      0: return 8'hFF;
      1: return 8'hFF;
      2: return 8'h55;
      default: return (lvl >= 1 && lvl <= NL) ? (8'h1 << (2 * (lvl - 1) + 1)) : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] en_pat(input int p);
    case (p)
      1: return 8'h00;
      2: return 8'hAA;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    n_chk = 0;
    n_fail = 0;
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int stepn;
    rst_n = 1'b0;
    exc_valid = 1'b0; exc_idx = '0; pend_level = '0;
    int_set = '0; int_en = '0; ps_in = '0; pc_in = '0; vbase_in = 32'h6000_0000;
    level_masks = {lmask(4), lmask(3), lmask(2), lmask(1)};
    for (int c = 0; c < 2; c++) begin
      m_pc[c] = '0; m_ps[c] = '0; m_tk[c] = 1'b0; m_cause[c] = '0; m_depc[c] = '0;
      for (int l = 0; l < 4; l++) m_epc[c][l] = '0;
      for (int l = 0; l < 3; l++) m_eps[c][l] = '0;
    end
    repeat (3) @(negedge clk);
    // R11: everything zero while reset is held
    scen = "R11";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // interrupt sweep: bases x mask patterns x levels x current level x mode bits
    stepn = 0;
    for (int vb = 0; vb < 2; vb++) begin
      vbase_in = (vb == 0) ? 32'h6000_0000 : 32'h1234_0000;
      for (int p = 0; p < 4; p++) begin
        for (int lvl = 0; lvl < 7; lvl++) begin
          for (int cur = 0; cur < 5; cur++) begin
            for (int fl = 0; fl < 4; fl++) begin
              exc_valid  = 1'b0;
              pend_level = 4'(lvl);
              int_set    = set_pat(p, lvl);
              int_en     = en_pat(p);
              ps_in      = {~2'(fl), fl[1], fl[0], 4'(cur)};
              pc_in      = 32'h0010_0000 + 32'(stepn) * 4;
              stepn++;
              do_step();
            end
          end
        end
      end
    end

    // exceptions alone and colliding with interrupts (R7, R8, R9)
    for (int ix = 0; ix < 16; ix++) begin
      for (int il = 0; il < 3; il++) begin
        exc_valid  = 1'b1;
        exc_idx    = 4'(ix);
        pend_level = (il == 0) ? 4'd0 : ((il == 1) ? 4'd1 : 4'd2);
        int_set    = 8'hFF;
        int_en     = 8'hFF;
        ps_in      = {2'b01, 1'b1, 1'(ix & 1), 4'd0};
        pc_in      = 32'h0080_0000 + 32'(ix) * 16 + 32'(il);
        do_step();
      end
    end

    // strobe drops after an idle cycle (R10)
    exc_valid = 1'b0; pend_level = 4'd0;
    do_step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule